// File: doc/BRIEF.md
# Stereo De-emphasis Filter with Rate Selection

This block undoes the treble pre-boost that some recordings carry. It runs a first-order shelving IIR filter on each channel of a stereo stream of 24-bit signed PCM samples. The analog target has a 15 µs zero and a 50 µs pole. The response is flat at low frequency and falls to a shelf about 10 dB down above roughly 10.6 kHz. The digital corners scale with the sample rate, so the block holds three fixed-point coefficient sets, one each for 32 kHz, 44.1 kHz and 48 kHz streams. A two-bit field picks one of these sets or bypass.

Samples enter with a one-cycle valid strobe. Each filtered pair leaves one clock later with its own valid strobe. The filter is only meaningful in single-speed operation, so a speed input forces bypass whenever it is low. Any change of the effective selection wipes the history of both channels, so the new filter starts from rest instead of reacting to state built up under the old coefficients.

Top module: `deemph_top`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid is 0 and both sample outputs are 0.
- R2: outValid is 1 exactly one clock after a cycle with inValid high and 0 otherwise. The sample outputs hold their value in cycles where outValid is 0.
- R3: With rateSel = 2'b00 and singleSpeed high, each output sample equals the matching input sample, one clock later.
- R4: With singleSpeed low, the outputs equal the inputs one clock later, whatever the value of rateSel.
- R5: For rateSel 2'b01 (44.1 kHz), 2'b10 (48 kHz) and 2'b11 (32 kHz), a constant input settles to an output within 4 LSB of the input (unity DC gain).
- R6: For each of the three rates, an input alternating +A, −A settles to an output of the same sign as the input, with magnitude 0.3·A ± 0.005·A (the shelf at half the sample rate).
- R7: From rest, the first output for an impulse of amplitude A is b0·A within ±0.002·A. b0 is 0.42939 for 44.1 kHz, 0.42069 for 48 kHz and 0.46667 for 32 kHz.
- R8: The two channels keep separate state, so a stimulus on the left channel leaves the right output at 0 while the right input is 0.
- R9: A change of the effective selection clears the history of both channels. After the change, a zero input gives exactly 0 at the output.
- R10: Results saturate to the 24-bit signed range. A constant full-scale input of either sign never produces an output of the opposite sign, and it settles within 8 LSB of the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 2 | 00 bypass, 01 44.1 kHz, 10 48 kHz, 11 32 kHz |
| singleSpeed | input | 1 | High when the stream runs at single speed; low forces bypass |
| inValid | input | 1 | Input sample pair strobe |
| inLeft | input | 24 | Left input sample, two's complement |
| inRight | input | 24 | Right input sample, two's complement |
| outValid | output | 1 | Output sample pair strobe |
| outLeft | output | 24 | Left output sample |
| outRight | output | 24 | Right output sample |

## Verification
The filter is driven with three input patterns, and each one tests a different part of the response. A constant input checks the DC end. An alternating-sign input checks the shelf depth at half the sample rate. An impulse from rest isolates the leading coefficient, and this is the pattern that shows whether the three rate codes reach three distinct coefficient sets. Bypass and slow-speed runs must copy the input bit for bit. A zero sample just after a rate change shows whether the history was cleared. Constant full-scale inputs of both signs check that the output saturates and does not wrap.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

  localparam int SAMPLE_W  = 24;
  localparam int COEF_FRAC = 23;
  localparam int COEF_W    = 26;
  localparam int COEF_ONE  = 1 << COEF_FRAC;

  typedef enum logic [1:0] {
    RATE_OFF  = 2'b00,
    RATE_44K1 = 2'b01,
    RATE_48K  = 2'b10,
    RATE_32K  = 2'b11
  } rate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  run;
    logic  clear;
    logic  bypass;
    rate_e rate;
  } dpCtl_t;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] a1;
  } coefSet_t;

  // b1 is derived so that b0 + b1 == 1 + a1 exactly: unity DC gain
  function automatic coefSet_t makeSet(input int b0, input int a1);
    coefSet_t c;
    c.b0 = COEF_W'(b0);
    c.a1 = COEF_W'(a1);
    c.b1 = COEF_W'(COEF_ONE + a1 - b0);
    return c;
  endfunction

  // bilinear mapping of (1 + s*15us) / (1 + s*50us), Q23
  function automatic coefSet_t coefFor(input rate_e r);
    coefSet_t c;
    case (r)
      RATE_44K1: c = makeSet(3601985, -5287459);
      RATE_48K:  c = makeSet(3529001, -5495984);
      RATE_32K:  c = makeSet(3914684, -4394033);
      default:   c = makeSet(COEF_ONE, 0);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/deemph_ctrl.sv
module deemph_ctrl
  import deemph_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       singleSpeed,
  input  logic       inValid,
  output dpCtl_t     ctl,
  output coefSet_t   coef,
  output logic       outValid
);

  rate_e effRate;
  rate_e prevRate;

  always_comb begin
    effRate    = singleSpeed ? rate_e'(rateSel) : RATE_OFF;
    ctl.run    = inValid;
    ctl.rate   = effRate;
    ctl.bypass = (effRate == RATE_OFF);
    ctl.clear  = (effRate != prevRate);
    coef       = coefFor(effRate);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRate <= RATE_OFF;
      outValid <= 1'b0;
    end else begin
      prevRate <= effRate;
      outValid <= inValid;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_change_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && singleSpeed && $past(singleSpeed) && (rateSel != $past(rateSel)))
      |-> ctl.clear);

endmodule

// File: rtl/deemph_chan.sv
module deemph_chan
  import deemph_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int CW = COEF_W,
  parameter int CF = COEF_FRAC
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  coefSet_t      coef,
  input  logic [SW-1:0] sampleIn,
  output logic [SW-1:0] sampleOut
);

  localparam int ACC_W = SW + CW + 3;
  localparam logic signed [ACC_W-1:0] ROUND_V = ACC_W'(64'sd1 <<< (CF - 1));
  localparam logic signed [ACC_W-1:0] MAX_V =
    {{(ACC_W-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_V =
    {{(ACC_W-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic signed [SW-1:0]    xPrev, yPrev;
  logic signed [SW-1:0]    xHist, yHist;
  logic signed [ACC_W-1:0] xExt, xhExt, yhExt, b0Ext, b1Ext, a1Ext;
  logic signed [ACC_W-1:0] acc, scaled;
  logic signed [SW-1:0]    yNew;

  always_comb begin
    xHist  = ctl.clear ? '0 : xPrev;
    yHist  = ctl.clear ? '0 : yPrev;
    xExt   = ACC_W'($signed(sampleIn));
    xhExt  = ACC_W'(xHist);
    yhExt  = ACC_W'(yHist);
    b0Ext  = ACC_W'(coef.b0);
    b1Ext  = ACC_W'(coef.b1);
    a1Ext  = ACC_W'(coef.a1);
    acc    = xExt * b0Ext + xhExt * b1Ext - yhExt * a1Ext + ROUND_V;
    scaled = acc >>> CF;
    if (scaled > MAX_V)      yNew = MAX_V[SW-1:0];
    else if (scaled < MIN_V) yNew = MIN_V[SW-1:0];
    else                     yNew = scaled[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xPrev     <= '0;
      yPrev     <= '0;
      sampleOut <= '0;
    end else begin
      if (ctl.clear) begin
        xPrev <= '0;
        yPrev <= '0;
      end
      if (ctl.run) begin
        if (ctl.bypass) begin
          sampleOut <= sampleIn;
        end else begin
          sampleOut <= yNew;
          xPrev     <= $signed(sampleIn);
          yPrev     <= yNew;
        end
      end
    end
  end

  p_bypass_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && ctl.bypass) |=> (sampleOut == $past(sampleIn)));
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> $stable(sampleOut));
  p_state_wiped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clear && !ctl.run) |=> (xPrev == '0 && yPrev == '0));

endmodule

// File: rtl/deemph_top.sv
module deemph_top
  import deemph_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          rateSel,
  input  logic                singleSpeed,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);

  localparam int NUM_CH = 2;

  dpCtl_t   ctl;
  coefSet_t coef;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] chIn, chOut;

  assign chIn     = {inRight, inLeft};
  assign outLeft  = chOut[0];
  assign outRight = chOut[1];

  deemph_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rateSel    (rateSel),
    .singleSpeed(singleSpeed),
    .inValid    (inValid),
    .ctl        (ctl),
    .coef       (coef),
    .outValid   (outValid)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    deemph_chan u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (ctl),
      .coef     (coef),
      .sampleIn (chIn[ch]),
      .sampleOut(chOut[ch])
    );
  end

  p_slow_passthru_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!singleSpeed && inValid) |=> (outLeft == $past(inLeft) && outRight == $past(inRight)));

endmodule

// File: tb/sim_deemph_top.sv
`timescale 1ns/1ps
module sim_deemph_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  rateSel = 2'b00;
  logic        singleSpeed = 1'b1;
  logic        inValid = 1'b0;
  logic [23:0] inLeft = '0, inRight = '0;
  logic        outValid;
  logic [23:0] outLeft, outRight;

  int checks = 0;
  int errors = 0;
  int gotL, gotR;
  bit gotV;
  bit done = 0;

  always #10 clk = ~clk;

  deemph_top u0 (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .singleSpeed(singleSpeed),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendSample(input int l, input int r);
    @(negedge clk);
    inValid = 1'b1;
    inLeft  = 24'(l);
    inRight = 24'(r);
    @(negedge clk);
    inValid = 1'b0;
    gotV = outValid;
    gotL = int'($signed(outLeft));
    gotR = int'($signed(outRight));
  endtask

  // pass through bypass so the next selection starts from cleared state
  task automatic selectRate(input logic [1:0] r);
    @(negedge clk);
    rateSel = 2'b00;
    @(negedge clk);
    rateSel = r;
  endtask

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic testReset();
    check(outValid == 1'b0, "R1 valid in reset", int'(outValid), 0);
    check(outLeft == '0 && outRight == '0, "R1 data in reset", int'($signed(outLeft)), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid after reset", int'(outValid), 0);
    check(outLeft == '0, "R1 left after reset", int'($signed(outLeft)), 0);
  endtask

  task automatic testLatency();
    selectRate(2'b01);
    sendSample(100000, -50000);
    check(gotV == 1'b1, "R2 valid one clock later", int'(gotV), 1);
    @(negedge clk);
    check(outValid == 1'b0, "R2 valid drops", int'(outValid), 0);
    check(int'($signed(outLeft)) == gotL, "R2 output held", int'($signed(outLeft)), gotL);
  endtask

  task automatic testBypass();
    selectRate(2'b00);
    sendSample(1234567, -7654321);
    check(gotL == 1234567, "R3 bypass left", gotL, 1234567);
    check(gotR == -7654321, "R3 bypass right", gotR, -7654321);
    sendSample(-8388608, 8388607);
    check(gotL == -8388608 && gotR == 8388607, "R3 bypass extremes", gotL, -8388608);
  endtask

  task automatic testSlowMode();
    selectRate(2'b11);
    @(negedge clk); singleSpeed = 1'b0;
    sendSample(2000000, 3000000);
    check(gotL == 2000000 && gotR == 3000000, "R4 slow mode copies", gotL, 2000000);
    sendSample(0, 0);
    check(gotL == 0, "R4 slow mode no history", gotL, 0);
    @(negedge clk); singleSpeed = 1'b1;
  endtask

  task automatic testDc(input logic [1:0] r);
    selectRate(r);
    for (int i = 0; i < 80; i++) sendSample(1000000, -300000);
    check(absI(gotL - 1000000) <= 4, $sformatf("R5 dc left rate %0d", r), gotL, 1000000);
    check(absI(gotR + 300000) <= 4, $sformatf("R5 dc right rate %0d", r), gotR, -300000);
  endtask

  task automatic testShelf(input logic [1:0] r);
    selectRate(r);
    for (int i = 0; i < 80; i++) sendSample((i % 2 == 0) ? 1000000 : -1000000, 0);
    // last input was -1000000
    check(gotL < 0 && absI(absI(gotL) - 300000) <= 5000,
          $sformatf("R6 shelf rate %0d", r), gotL, -300000);
  endtask

  task automatic testImpulse(input logic [1:0] r, input int expY);
    selectRate(r);
    sendSample(1048576, 0);
    check(absI(gotL - expY) <= 2097, $sformatf("R7 impulse rate %0d", r), gotL, expY);
    check(gotR == 0, "R8 right untouched", gotR, 0);
    sendSample(0, 0);
    check(gotL != 0 && gotR == 0, "R8 left tail only", gotR, 0);
  endtask

  task automatic testClear();
    @(negedge clk); rateSel = 2'b01;
    for (int i = 0; i < 30; i++) sendSample(1000000, 1000000);
    @(negedge clk); rateSel = 2'b10;
    sendSample(0, 0);
    check(gotL == 0, "R9 left cleared on change", gotL, 0);
    check(gotR == 0, "R9 right cleared on change", gotR, 0);
  endtask

  task automatic testFullScale();
    int flips;
    selectRate(2'b11);
    flips = 0;
    for (int i = 0; i < 80; i++) begin
      sendSample(-8388608, 8388607);
      if (gotL > 0 || gotR < 0) flips++;
    end
    check(flips == 0, "R10 no sign wrap", flips, 0);
    check(absI(gotL + 8388608) <= 8, "R10 negative full scale", gotL, -8388608);
    check(absI(gotR - 8388607) <= 8, "R10 positive full scale", gotR, 8388607);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLatency();
    testBypass();
    testSlowMode();
    testDc(2'b01); testDc(2'b10); testDc(2'b11);
    testShelf(2'b01); testShelf(2'b10); testShelf(2'b11);
    testImpulse(2'b01, 450249);
    testImpulse(2'b10, 441124);
    testImpulse(2'b11, 489335);
    testClear();
    testFullScale();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule